// File: doc/BRIEF.md
# Compressed-to-Full Instruction Expander

This block turns one 16-bit compressed instruction of the 32-bit integer RISC-V base into the 32-bit instruction word that does the same thing. It also raises a flag when the halfword is not a legal compressed instruction. It is purely combinational. It is meant to sit between instruction fetch and the main decoder, so that the main decoder only ever sees full-width words.

It covers the integer compressed forms: register moves and adds, immediate adds (including the stack-pointer forms), the logical and subtract register ops, shifts, loads and stores (register-based and stack-based), jumps, branches on zero, indirect jumps and the breakpoint. Floating-point forms and the wider-address-space forms are rejected.

Decoding has two steps. Match patterns with don't-care bits first pick one instruction class, and they exclude the reserved encodings. Each class then selects a set of steering controls: the opcode, the function fields, the output format, the source of each register field and the immediate layout. These controls assemble the output word. Whenever the halfword is flagged illegal, the output word is all zeros.

Top module: `rvc_expander`

## Requirements
- R1: When the illegal flag is low, output bits [1:0] are 11. When the flag is high, the output word is 0x00000000. Any halfword whose bits [1:0] are 11 is illegal.
- R2: The full register fields are taken from input bits [11:7] (destination or first source) and [6:2] (second source). The 3-bit compressed fields map to registers 8..15 as {01, bits[9:7]} and {01, bits[4:2]}.
- R3: In quadrant 10 with bits [15:13]=100, a nonzero bits[6:2] gives a register add. It is add rd,x0,rs2 when bit 12 is 0 and add rd,rd,rs2 when bit 12 is 1. A zero bits[6:2] with nonzero bits[11:7] gives an indirect jump (opcode 1100111, offset 0) that links to x0 when bit 12 is 0 and to x1 when bit 12 is 1. A zero bits[6:2] with zero bits[11:7] and bit 12 clear is illegal.
- R4: Halfword 0x9002 expands to 0x00100073.
- R5: The stack-relative add-upper form (quadrant 00, bits[15:13]=000) is illegal when bits[12:5] are all zero, so 0x0000 is illegal. The stack-pointer adjust (quadrant 01, 011, rd=2) is illegal when bit 12 and bits[6:2] are all zero. Otherwise both give addi on x2 with their scaled offsets.
- R6: The load-upper form (quadrant 01, 011, rd not 2) is illegal when rd=0 or when {bit12, bits[6:2]} is zero. Otherwise it gives opcode 0110111 with that 6-bit value sign-extended into output bits [31:12].
- R7: The three shifts are illegal when bit 12 is 1. The left shift uses funct3 001. The logical and arithmetic right shifts use funct3 101, and the arithmetic one also sets output bit 30. The shift amount is bits[6:2].
- R8: Quadrant 01 with bits[15:10]=100011 selects, by bits[6:5] = 00/01/10/11, subtract/xor/or/and with opcode 0110011. The funct3 values are 000 with bit 30 set, 100, 110 and 111.
- R9: The two unconditional jumps give opcode 1101111 with rd=x1 (bits[15:13]=001) or rd=x0 (101). The two branches compare rs1' with x0 using funct3 000 (110) or 001 (111). All offsets are sign-extended.
- R10: Word loads and stores use funct3 010. The stack forms use base x2 with zero-extended offsets up to 252. The register forms use base rs1' with zero-extended offsets up to 124.
- R11: The plain immediate add, load-immediate (rs1=x0) and and-immediate forms take the sign-extended value {bit12, bits[6:2]} and are legal for every operand value.
- R12: In quadrants 00 and 10, the bits[15:13] values that the integer set does not use are illegal. So is bits[15:10]=100111 in quadrant 01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 16 | Compressed instruction halfword |
| word_o | output | 32 | Expanded 32-bit instruction word, zero when illegal |
| illegal_o | output | 1 | High when the halfword is not a legal integer compressed instruction |

## Verification
Both results are combinational, so each is due in the same clock cycle that its halfword is applied, with no register on the path. The driver applies a new halfword on each rising edge and pushes the expected word and flag into the scoreboard queue. The monitor pops the entry and compares it at the following falling edge, after the logic has settled and before the next halfword arrives. Hand-computed words cover each class and reserved case. A sweep of all 65536 halfwords then checks each one against an encoder model written separately in the bench.

// File: rtl/rvc_pkg.sv
// Package: shared widths, instruction classes and steering controls
// for the compressed instruction expander.
// Assumes a 32-bit integer base; only integer compressed forms exist here.
package rvc_pkg;

    localparam int HALF_W = 16;
    localparam int WORD_W = 32;
    localparam int REG_W  = 5;
    localparam int OPC_W  = 7;
    localparam int F3_W   = 3;
    localparam int F7_W   = 7;

    // One value per recognised compressed instruction class
    typedef enum logic [4:0] {
        OP_ILL, OP_ADDI4SPN, OP_LW, OP_SW, OP_ADDI, OP_JAL, OP_LI,
        OP_ADDI16SP, OP_LUI, OP_SRLI, OP_SRAI, OP_ANDI, OP_SUB, OP_XOR,
        OP_OR, OP_AND, OP_J, OP_BEQZ, OP_BNEZ, OP_SLLI, OP_LWSP, OP_JR,
        OP_MV, OP_EBREAK, OP_JALR, OP_ADD, OP_SWSP
    } rvc_op_e;

    // Output word layout
    typedef enum logic [2:0] {
        FMT_NONE, FMT_R, FMT_SH, FMT_I, FMT_S, FMT_B, FMT_U, FMT_J
    } fmt_e;

    // Where a register number comes from
    typedef enum logic [2:0] {
        RS_ZERO, RS_ONE, RS_TWO, RS_FULL_HI, RS_FULL_LO, RS_CMP_HI, RS_CMP_LO
    } reg_src_e;

    // Which immediate shuffle applies
    typedef enum logic [3:0] {
        IM_NONE, IM_ONE, IM_CIW, IM_CL, IM_LWSP, IM_SWSP, IM_S6, IM_SHAMT,
        IM_SP16, IM_LUI, IM_CB, IM_CJ
    } imm_src_e;

    typedef struct packed {
        logic [OPC_W-1:0] opc;
        logic [F3_W-1:0]  f3;
        logic [F7_W-1:0]  f7;
        fmt_e             fmt;
        reg_src_e         rd;
        reg_src_e         rs1;
        reg_src_e         rs2;
        imm_src_e         imm;
    } ctrl_t;

    localparam logic [OPC_W-1:0] OPC_OPIMM  = 7'b0010011;
    localparam logic [OPC_W-1:0] OPC_LOAD   = 7'b0000011;
    localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;
    localparam logic [OPC_W-1:0] OPC_OP     = 7'b0110011;
    localparam logic [OPC_W-1:0] OPC_LUI    = 7'b0110111;
    localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
    localparam logic [OPC_W-1:0] OPC_JALR   = 7'b1100111;
    localparam logic [OPC_W-1:0] OPC_JAL    = 7'b1101111;
    localparam logic [OPC_W-1:0] OPC_SYSTEM = 7'b1110011;
    localparam logic [F7_W-1:0]  F7_ALT     = 7'b0100000;

    // Per-class steering controls
    function automatic ctrl_t op_ctrl(rvc_op_e op);
        ctrl_t c;
        c = '{opc: '0, f3: '0, f7: '0, fmt: FMT_NONE, rd: RS_ZERO,
              rs1: RS_ZERO, rs2: RS_ZERO, imm: IM_NONE};
        case (op)
            OP_ADDI4SPN: c = '{OPC_OPIMM, 3'b000, '0, FMT_I, RS_CMP_LO, RS_TWO, RS_ZERO, IM_CIW};
            OP_LW:       c = '{OPC_LOAD, 3'b010, '0, FMT_I, RS_CMP_LO, RS_CMP_HI, RS_ZERO, IM_CL};
            OP_SW:       c = '{OPC_STORE, 3'b010, '0, FMT_S, RS_ZERO, RS_CMP_HI, RS_CMP_LO, IM_CL};
            OP_ADDI:     c = '{OPC_OPIMM, 3'b000, '0, FMT_I, RS_FULL_HI, RS_FULL_HI, RS_ZERO, IM_S6};
            OP_JAL:      c = '{OPC_JAL, 3'b000, '0, FMT_J, RS_ONE, RS_ZERO, RS_ZERO, IM_CJ};
            OP_LI:       c = '{OPC_OPIMM, 3'b000, '0, FMT_I, RS_FULL_HI, RS_ZERO, RS_ZERO, IM_S6};
            OP_ADDI16SP: c = '{OPC_OPIMM, 3'b000, '0, FMT_I, RS_TWO, RS_TWO, RS_ZERO, IM_SP16};
            OP_LUI:      c = '{OPC_LUI, 3'b000, '0, FMT_U, RS_FULL_HI, RS_ZERO, RS_ZERO, IM_LUI};
            OP_SRLI:     c = '{OPC_OPIMM, 3'b101, '0, FMT_SH, RS_CMP_HI, RS_CMP_HI, RS_ZERO, IM_SHAMT};
            OP_SRAI:     c = '{OPC_OPIMM, 3'b101, F7_ALT, FMT_SH, RS_CMP_HI, RS_CMP_HI, RS_ZERO, IM_SHAMT};
            OP_ANDI:     c = '{OPC_OPIMM, 3'b111, '0, FMT_I, RS_CMP_HI, RS_CMP_HI, RS_ZERO, IM_S6};
            OP_SUB:      c = '{OPC_OP, 3'b000, F7_ALT, FMT_R, RS_CMP_HI, RS_CMP_HI, RS_CMP_LO, IM_NONE};
            OP_XOR:      c = '{OPC_OP, 3'b100, '0, FMT_R, RS_CMP_HI, RS_CMP_HI, RS_CMP_LO, IM_NONE};
            OP_OR:       c = '{OPC_OP, 3'b110, '0, FMT_R, RS_CMP_HI, RS_CMP_HI, RS_CMP_LO, IM_NONE};
            OP_AND:      c = '{OPC_OP, 3'b111, '0, FMT_R, RS_CMP_HI, RS_CMP_HI, RS_CMP_LO, IM_NONE};
            OP_J:        c = '{OPC_JAL, 3'b000, '0, FMT_J, RS_ZERO, RS_ZERO, RS_ZERO, IM_CJ};
            OP_BEQZ:     c = '{OPC_BRANCH, 3'b000, '0, FMT_B, RS_ZERO, RS_CMP_HI, RS_ZERO, IM_CB};
            OP_BNEZ:     c = '{OPC_BRANCH, 3'b001, '0, FMT_B, RS_ZERO, RS_CMP_HI, RS_ZERO, IM_CB};
            OP_SLLI:     c = '{OPC_OPIMM, 3'b001, '0, FMT_SH, RS_FULL_HI, RS_FULL_HI, RS_ZERO, IM_SHAMT};
            OP_LWSP:     c = '{OPC_LOAD, 3'b010, '0, FMT_I, RS_FULL_HI, RS_TWO, RS_ZERO, IM_LWSP};
            OP_JR:       c = '{OPC_JALR, 3'b000, '0, FMT_I, RS_ZERO, RS_FULL_HI, RS_ZERO, IM_NONE};
            OP_MV:       c = '{OPC_OP, 3'b000, '0, FMT_R, RS_FULL_HI, RS_ZERO, RS_FULL_LO, IM_NONE};
            OP_EBREAK:   c = '{OPC_SYSTEM, 3'b000, '0, FMT_I, RS_ZERO, RS_ZERO, RS_ZERO, IM_ONE};
            OP_JALR:     c = '{OPC_JALR, 3'b000, '0, FMT_I, RS_ONE, RS_FULL_HI, RS_ZERO, IM_NONE};
            OP_ADD:      c = '{OPC_OP, 3'b000, '0, FMT_R, RS_FULL_HI, RS_FULL_HI, RS_FULL_LO, IM_NONE};
            OP_SWSP:     c = '{OPC_STORE, 3'b010, '0, FMT_S, RS_ZERO, RS_TWO, RS_FULL_LO, IM_SWSP};
            default:     c = c;
        endcase
        return c;
    endfunction

    // Register number from a source selector and the operand bits [11:2]
    function automatic logic [REG_W-1:0] pick_reg(reg_src_e s, logic [11:2] f);
        case (s)
            RS_ONE:     return 5'd1;
            RS_TWO:     return 5'd2;
            RS_FULL_HI: return f[11:7];
            RS_FULL_LO: return f[6:2];
            RS_CMP_HI:  return {2'b01, f[9:7]};
            RS_CMP_LO:  return {2'b01, f[4:2]};
            default:    return 5'd0;
        endcase
    endfunction

endpackage

// File: rtl/rvc_decode.sv
// Module: rvc_decode
// Classifies a compressed halfword by don't-care match patterns and
// rejects reserved operand combinations. Returns OP_ILL for no match.
// Assumes nothing about the halfword; quadrant 11 never matches.
module rvc_decode
    import rvc_pkg::*;
(
    input  logic [HALF_W-1:0] instr_i,
    output rvc_op_e           op_o
);

    logic nz_ci;      // bit 12 or any of bits 6:2 set
    logic rd_zero;
    logic rs2_zero;

    // Operand-zero detectors used by the reserved-case rules
    always_comb begin
        nz_ci    = instr_i[12] | (|instr_i[6:2]);
        rd_zero  = (instr_i[11:7] == '0);
        rs2_zero = (instr_i[6:2] == '0);
    end

    // Pattern match with legality refinement
    always_comb begin
        op_o = OP_ILL;
        casez (instr_i)
            16'b000?_????_????_??00: op_o = (instr_i[12:5] != '0) ? OP_ADDI4SPN : OP_ILL;
            16'b010?_????_????_??00: op_o = OP_LW;
            16'b110?_????_????_??00: op_o = OP_SW;
            16'b000?_????_????_??01: op_o = OP_ADDI;
            16'b001?_????_????_??01: op_o = OP_JAL;
            16'b010?_????_????_??01: op_o = OP_LI;
            16'b011?_????_????_??01: begin
                if (instr_i[11:7] == 5'd2)
                    op_o = nz_ci ? OP_ADDI16SP : OP_ILL;
                else
                    op_o = (!rd_zero && nz_ci) ? OP_LUI : OP_ILL;
            end
            16'b1000_00??_????_??01: op_o = OP_SRLI;
            16'b1000_01??_????_??01: op_o = OP_SRAI;
            16'b100?_10??_????_??01: op_o = OP_ANDI;
            16'b1000_11??_?00?_??01: op_o = OP_SUB;
            16'b1000_11??_?01?_??01: op_o = OP_XOR;
            16'b1000_11??_?10?_??01: op_o = OP_OR;
            16'b1000_11??_?11?_??01: op_o = OP_AND;
            16'b101?_????_????_??01: op_o = OP_J;
            16'b110?_????_????_??01: op_o = OP_BEQZ;
            16'b111?_????_????_??01: op_o = OP_BNEZ;
            16'b0000_????_????_??10: op_o = OP_SLLI;
            16'b010?_????_????_??10: op_o = OP_LWSP;
            16'b1000_????_????_??10: begin
                if (rs2_zero) op_o = rd_zero ? OP_ILL : OP_JR;
                else          op_o = OP_MV;
            end
            16'b1001_????_????_??10: begin
                if (rs2_zero) op_o = rd_zero ? OP_EBREAK : OP_JALR;
                else          op_o = OP_ADD;
            end
            16'b110?_????_????_??10: op_o = OP_SWSP;
            default:                 op_o = OP_ILL;
        endcase
    end

endmodule

// File: rtl/rvc_imm.sv
// Module: rvc_imm
// Reassembles the scattered immediate bits of a compressed halfword into
// a 32-bit value (sign- or zero-extended as the layout demands).
// Assumes the caller selects the layout from the decoded class.
module rvc_imm
    import rvc_pkg::*;
(
    input  logic [12:2]       body_i,
    input  imm_src_e          sel_i,
    output logic [WORD_W-1:0] imm_o
);

    logic s;   // sign bit of every signed compressed immediate

    // Layout selection and bit reshuffle
    always_comb begin
        s = body_i[12];
        case (sel_i)
            IM_ONE:   imm_o = 32'd1;
            IM_CIW:   imm_o = {22'b0, body_i[10:7], body_i[12:11], body_i[5], body_i[6], 2'b00};
            IM_CL:    imm_o = {25'b0, body_i[5], body_i[12:10], body_i[6], 2'b00};
            IM_LWSP:  imm_o = {24'b0, body_i[3:2], body_i[12], body_i[6:4], 2'b00};
            IM_SWSP:  imm_o = {24'b0, body_i[8:7], body_i[12:9], 2'b00};
            IM_S6:    imm_o = {{26{s}}, s, body_i[6:2]};
            IM_SHAMT: imm_o = {27'b0, body_i[6:2]};
            IM_SP16:  imm_o = {{22{s}}, s, body_i[4:3], body_i[5], body_i[2], body_i[6], 4'b0000};
            IM_LUI:   imm_o = {{14{s}}, s, body_i[6:2], 12'b0};
            IM_CB:    imm_o = {{23{s}}, s, body_i[6:5], body_i[2], body_i[11:10], body_i[4:3], 1'b0};
            IM_CJ:    imm_o = {{20{s}}, s, body_i[8], body_i[10:9], body_i[6], body_i[7],
                               body_i[2], body_i[11], body_i[5:3], 1'b0};
            default:  imm_o = '0;
        endcase
    end

endmodule

// File: rtl/rvc_assemble.sv
// Module: rvc_assemble
// Places opcode, function fields, register numbers and immediate into the
// 32-bit word according to the output format. FMT_NONE yields zero.
// Assumes the immediate is already extended to 32 bits.
module rvc_assemble
    import rvc_pkg::*;
(
    input  ctrl_t             ctrl_i,
    input  logic [11:2]       regs_i,
    input  logic [WORD_W-1:0] imm_i,
    output logic [WORD_W-1:0] word_o
);

    logic [REG_W-1:0] rd, rs1, rs2;

    // Register field steering
    always_comb begin
        rd  = pick_reg(ctrl_i.rd,  regs_i);
        rs1 = pick_reg(ctrl_i.rs1, regs_i);
        rs2 = pick_reg(ctrl_i.rs2, regs_i);
    end

    // Word layout per format
    always_comb begin
        case (ctrl_i.fmt)
            FMT_R:  word_o = {ctrl_i.f7, rs2, rs1, ctrl_i.f3, rd, ctrl_i.opc};
            FMT_SH: word_o = {ctrl_i.f7, imm_i[4:0], rs1, ctrl_i.f3, rd, ctrl_i.opc};
            FMT_I:  word_o = {imm_i[11:0], rs1, ctrl_i.f3, rd, ctrl_i.opc};
            FMT_S:  word_o = {imm_i[11:5], rs2, rs1, ctrl_i.f3, imm_i[4:0], ctrl_i.opc};
            FMT_B:  word_o = {imm_i[12], imm_i[10:5], rs2, rs1, ctrl_i.f3,
                              imm_i[4:1], imm_i[11], ctrl_i.opc};
            FMT_U:  word_o = {imm_i[31:12], rd, ctrl_i.opc};
            FMT_J:  word_o = {imm_i[20], imm_i[10:1], imm_i[11], imm_i[19:12], rd, ctrl_i.opc};
            default: word_o = '0;
        endcase
    end

endmodule

// File: rtl/rvc_expander.sv
// Module: rvc_expander (top)
// Expands a 16-bit integer compressed instruction into its 32-bit form and
// flags illegal halfwords; the word is zero whenever the flag is high.
// Purely combinational; no clock or reset is needed.
module rvc_expander
    import rvc_pkg::*;
(
    input  logic [15:0] instr_i,
    output logic [31:0] word_o,
    output logic        illegal_o
);

    rvc_op_e           op;
    ctrl_t             ctrl;
    logic [WORD_W-1:0] imm;

    rvc_decode i_decode (
        .instr_i (instr_i),
        .op_o    (op)
    );

    // Class to steering controls
    always_comb ctrl = op_ctrl(op);

    rvc_imm i_imm (
        .body_i (instr_i[12:2]),
        .sel_i  (ctrl.imm),
        .imm_o  (imm)
    );

    rvc_assemble i_assemble (
        .ctrl_i (ctrl),
        .regs_i (instr_i[11:2]),
        .imm_i  (imm),
        .word_o (word_o)
    );

    // Illegal flag from the class
    always_comb illegal_o = (op == OP_ILL);

    // Output-level properties across decoder and assembler
    always_comb begin
        if (!illegal_o)
            assert_low_bits_R1: assert (word_o[1:0] == 2'b11);
        if (illegal_o)
            assert_zero_word_R1: assert (word_o == '0);
        if (instr_i[1:0] == 2'b11)
            assert_quad3_R1: assert (illegal_o);
        if (!illegal_o && word_o[6:0] == OPC_JALR)
            assert_jump_base_R3: assert (word_o[19:15] != '0);
        if (!illegal_o && word_o == 32'h0010_0073)
            assert_break_R4: assert (instr_i == 16'h9002);
        if (!illegal_o && word_o[6:0] == OPC_LUI)
            assert_upper_R6: assert (word_o[31:12] != '0 && word_o[11:7] != 5'd0
                                     && word_o[11:7] != 5'd2);
        if (!illegal_o && word_o[6:0] == OPC_OPIMM && word_o[13:12] == 2'b01)
            assert_shamt_R7: assert (word_o[25] == 1'b0);
        if (!illegal_o && (word_o[6:0] == OPC_LOAD || word_o[6:0] == OPC_STORE))
            assert_word_access_R10: assert (word_o[14:12] == 3'b010);
    end

endmodule

// File: tb/test_rvc_expander.sv
module test_rvc_expander;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [15:0] h;
        logic        ill;
        logic [31:0] w;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] instr = 16'h0000;
    logic [31:0] word;
    logic        illegal;
    int          nchk = 0;
    int          nfail = 0;
    bit          done = 1'b0;
    exp_t        sb[$];

    rvc_expander i_rvc_expander (
        .instr_i   (instr),
        .word_o    (word),
        .illegal_o (illegal)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------- independent encoder model ----------
    function automatic logic [31:0] sx(input logic [31:0] v, input int b);
        for (int i = b + 1; i < 32; i++) v[i] = v[b];
        return v;
    endfunction

    function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [4:0] b2,
        input logic [4:0] b1, input logic [2:0] f3, input logic [4:0] d, input logic [6:0] o);
        return {f7, b2, b1, f3, d, o};
    endfunction

    function automatic logic [31:0] enc_i(input logic [11:0] k, input logic [4:0] b1,
        input logic [2:0] f3, input logic [4:0] d, input logic [6:0] o);
        return {k, b1, f3, d, o};
    endfunction

    function automatic logic [31:0] enc_s(input logic [11:0] k, input logic [4:0] b2,
        input logic [4:0] b1);
        return {k[11:5], b2, b1, 3'b010, k[4:0], 7'h23};
    endfunction

    function automatic logic [31:0] enc_b(input logic [12:0] k, input logic [4:0] b1,
        input logic [2:0] f3);
        return {k[12], k[10:5], 5'd0, b1, f3, k[4:1], k[11], 7'h63};
    endfunction

    function automatic logic [31:0] enc_j(input logic [20:0] k, input logic [4:0] d);
        return {k[20], k[10:1], k[11], k[19:12], d, 7'h6F};
    endfunction

    function automatic exp_t model(input logic [15:0] h);
        exp_t        e;
        logic [4:0]  rH = h[11:7];
        logic [4:0]  rL = h[6:2];
        logic [4:0]  pH = {2'b01, h[9:7]};
        logic [4:0]  pL = {2'b01, h[4:2]};
        logic [31:0] k6 = sx({26'b0, h[12], h[6:2]}, 5);
        logic [31:0] t = '0;
        e.h = h; e.ill = 1'b1; e.w = '0; e.tag = "R12";
        if (h[1:0] == 2'b11) begin e.tag = "R1"; return e; end
        case ({h[1:0], h[15:13]})
            5'b00_000: begin
                e.tag = "R5";
                t[9:6] = h[10:7]; t[5:4] = h[12:11]; t[3] = h[5]; t[2] = h[6];
                if (t != 0) begin e.ill = 0; e.w = enc_i(t[11:0], 5'd2, 3'b000, pL, 7'h13); end
            end
            5'b00_010, 5'b00_110: begin
                e.tag = "R10";
                t[6] = h[5]; t[5:3] = h[12:10]; t[2] = h[6];
                e.ill = 0;
                e.w = h[15] ? enc_s(t[11:0], pL, pH) : enc_i(t[11:0], pH, 3'b010, pL, 7'h03);
            end
            5'b01_000: begin e.tag = "R11"; e.ill = 0; e.w = enc_i(k6[11:0], rH, 3'b000, rH, 7'h13); end
            5'b01_010: begin e.tag = "R11"; e.ill = 0; e.w = enc_i(k6[11:0], 5'd0, 3'b000, rH, 7'h13); end
            5'b01_001, 5'b01_101: begin
                e.tag = "R9";
                t[11] = h[12]; t[10] = h[8]; t[9:8] = h[10:9]; t[7] = h[6]; t[6] = h[7];
                t[5] = h[2]; t[4] = h[11]; t[3:1] = h[5:3];
                t = sx(t, 11);
                e.ill = 0; e.w = enc_j(t[20:0], h[15] ? 5'd0 : 5'd1);
            end
            5'b01_011: begin
                if (rH == 5'd2) begin
                    e.tag = "R5";
                    t[9] = h[12]; t[8:7] = h[4:3]; t[6] = h[5]; t[5] = h[2]; t[4] = h[6];
                    t = sx(t, 9);
                    if (t != 0) begin e.ill = 0; e.w = enc_i(t[11:0], 5'd2, 3'b000, 5'd2, 7'h13); end
                end else begin
                    e.tag = "R6";
                    if (rH != 0 && k6 != 0) begin e.ill = 0; e.w = {k6[19:0], rH, 7'h37}; end
                end
            end
            5'b01_100: begin
                case (h[11:10])
                    2'b00, 2'b01: begin
                        e.tag = "R7";
                        if (!h[12]) begin
                            e.ill = 0;
                            e.w = enc_r(h[10] ? 7'h20 : 7'h00, rL, pH, 3'b101, pH, 7'h13);
                        end
                    end
                    2'b10: begin e.tag = "R11"; e.ill = 0; e.w = enc_i(k6[11:0], pH, 3'b111, pH, 7'h13); end
                    default: begin
                        e.tag = "R8";
                        if (!h[12]) begin
                            e.ill = 0;
                            case (h[6:5])
                                2'b00:   e.w = enc_r(7'h20, pL, pH, 3'b000, pH, 7'h33);
                                2'b01:   e.w = enc_r(7'h00, pL, pH, 3'b100, pH, 7'h33);
                                2'b10:   e.w = enc_r(7'h00, pL, pH, 3'b110, pH, 7'h33);
                                default: e.w = enc_r(7'h00, pL, pH, 3'b111, pH, 7'h33);
                            endcase
                        end else e.tag = "R12";
                    end
                endcase
            end
            5'b01_110, 5'b01_111: begin
                e.tag = "R9";
                t[8] = h[12]; t[7:6] = h[6:5]; t[5] = h[2]; t[4:3] = h[11:10]; t[2:1] = h[4:3];
                t = sx(t, 8);
                e.ill = 0; e.w = enc_b(t[12:0], pH, h[13] ? 3'b001 : 3'b000);
            end
            5'b10_000: begin
                e.tag = "R7";
                if (!h[12]) begin e.ill = 0; e.w = enc_r(7'h00, rL, rH, 3'b001, rH, 7'h13); end
            end
            5'b10_010: begin
                e.tag = "R10";
                t[7:6] = h[3:2]; t[5] = h[12]; t[4:2] = h[6:4];
                e.ill = 0; e.w = enc_i(t[11:0], 5'd2, 3'b010, rH, 7'h03);
            end
            5'b10_110: begin
                e.tag = "R10";
                t[7:6] = h[8:7]; t[5:2] = h[12:9];
                e.ill = 0; e.w = enc_s(t[11:0], rL, 5'd2);
            end
            5'b10_100: begin
                e.tag = "R3";
                if (rL != 0) begin
                    e.ill = 0; e.w = enc_r(7'h00, rL, h[12] ? rH : 5'd0, 3'b000, rH, 7'h33);
                end else if (rH != 0) begin
                    e.ill = 0; e.w = enc_i(12'd0, rH, 3'b000, h[12] ? 5'd1 : 5'd0, 7'h67);
                end else if (h[12]) begin
                    e.tag = "R4"; e.ill = 0; e.w = 32'h0010_0073;
                end
            end
            default: e.tag = "R12";
        endcase
        return e;
    endfunction

    // ---------- driver ----------
    task automatic drive(input exp_t e);
        @(posedge clk);
        instr <= e.h;
        sb.push_back(e);
    endtask

    task automatic drive_k(input logic [15:0] h, input logic ill, input logic [31:0] w,
                           input string tag);
        exp_t e;
        e.h = h; e.ill = ill; e.w = w; e.tag = tag;
        drive(e);
    endtask

    // ---------- monitor: results are due in the cycle they are applied ----------
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && sb.size() > 0) begin
            e = sb.pop_front();
            nchk++;
            if (illegal !== e.ill || word !== e.w) begin
                nfail++;
                $display("FAIL %s in=%h: actual ill=%b word=%h expected ill=%b word=%h",
                         e.tag, e.h, illegal, word, e.ill, e.w);
            end
        end
    end

    // ---------- watchdog ----------
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL R1 watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    // ---------- stimulus ----------
    initial begin
        repeat (2) @(posedge clk);
        rst_n <= 1'b1;
        // R1 reset-state halfword (all zero) is illegal with a zero word; also R5
        drive_k(16'h0000, 1'b1, 32'h0000_0000, "R1");
        drive_k(16'h0003, 1'b1, 32'h0000_0000, "R1");
        drive_k(16'h0001, 1'b0, 32'h0000_0013, "R11");
        drive_k(16'h9002, 1'b0, 32'h0010_0073, "R4");
        drive_k(16'h852e, 1'b0, 32'h00B0_0533, "R3");
        drive_k(16'h8082, 1'b0, 32'h0000_8067, "R3");
        drive_k(16'h9082, 1'b0, 32'h0000_80E7, "R3");
        drive_k(16'h8002, 1'b1, 32'h0000_0000, "R3");
        drive_k(16'h4398, 1'b0, 32'h0007_A703, "R2");
        drive_k(16'h0040, 1'b0, 32'h0041_0413, "R5");
        drive_k(16'h6105, 1'b0, 32'h0201_0113, "R5");
        drive_k(16'h6101, 1'b1, 32'h0000_0000, "R5");
        drive_k(16'h6785, 1'b0, 32'h0000_17B7, "R6");
        drive_k(16'h6005, 1'b1, 32'h0000_0000, "R6");
        drive_k(16'h6781, 1'b1, 32'h0000_0000, "R6");
        drive_k(16'h8005, 1'b0, 32'h0014_5413, "R7");
        drive_k(16'h9005, 1'b1, 32'h0000_0000, "R7");
        drive_k(16'h8c05, 1'b0, 32'h4094_0433, "R8");
        drive_k(16'hA001, 1'b0, 32'h0000_006F, "R9");
        drive_k(16'h2001, 1'b0, 32'h0000_00EF, "R9");
        drive_k(16'hC001, 1'b0, 32'h0004_0063, "R9");
        drive_k(16'h4000, 1'b0, 32'h0004_2403, "R10");
        drive_k(16'hC006, 1'b0, 32'h0011_2023, "R10");
        drive_k(16'h2000, 1'b1, 32'h0000_0000, "R12");
        drive_k(16'h9c05, 1'b1, 32'h0000_0000, "R12");
        // Full sweep of every halfword against the model
        for (int v = 0; v < 65536; v++) drive(model(v[15:0]));
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule